// File: doc/BRIEF.md
# Circular next-set-bit selector

This block picks the next slot for a round-robin scheduler. Software loads a pointer word and an eligibility mask, each `SLOTS` bits wide, with one write strobe. The block then presents a one-hot word that marks the first eligible slot after the pointer's position. The search runs upward and wraps from the top slot back to slot 0. Software reads that word and loads it back as the next pointer, so repeated use steps through every eligible slot in turn.

The selection is a linear ripple chain of `2*SLOTS` stages, so the gate count grows linearly with `SLOTS`. A pointer with no bit set counts as sitting just below slot 0. An all-ones detector on the inverted pointer bits (a NOR) injects the token at the start of the chain, so the lowest eligible slot wins. A pointer with several bits set is first reduced to its lowest set bit. The selected word depends combinationally on the held registers, so it is valid in the cycle after the write.

Top module: `rr_slot_picker`

## Requirements
- R1: A clock edge with `rst_n` low clears the held pointer and mask. After that edge `nxt_out` is all zeros and `nxt_valid` is low.
- R2: At a rising edge with `wr_en` high, the block loads `cur_in` and `mask_in`. With `wr_en` low, the held values and `nxt_out` stay unchanged whatever the inputs do.
- R3: Take a held pointer with exactly one bit set at index p, and a mask that is not empty. Then `nxt_out` has exactly one bit set, at the first mask index above p, counting upward modulo `SLOTS`. For example, with 4 slots, pointer 4'b1000 and mask 4'b1111 give 4'b0001.
- R4: If the pointer's own bit is the only set bit of the mask, `nxt_out` equals the pointer.
- R5: If the held pointer is all zeros and the mask is not empty, `nxt_out` is the lowest-index set bit of the mask.
- R6: If the held pointer has more than one bit set, only its lowest set bit acts as the pointer.
- R7: If the mask is all zeros, `nxt_out` is all zeros and `nxt_valid` is low. Otherwise `nxt_valid` is high and `nxt_out` is not zero.
- R8: `nxt_out` never has more than one bit set and never marks a slot that the held mask excludes.
- R9: Start from a zero pointer and write `nxt_out` back as the pointer each time. The result then visits the set mask bits in ascending order and wraps from the highest back to the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load strobe for pointer and mask |
| cur_in | input | SLOTS | Pointer word to load |
| mask_in | input | SLOTS | Eligibility mask to load |
| nxt_out | output | SLOTS | One-hot selected slot, zero if none |
| nxt_valid | output | 1 | High when the held mask has any eligible slot |

## Verification
The checker watches several rules on every cycle:
- `nxt_out` is one-hot or zero and stays inside the held mask.
- `nxt_valid` agrees with `nxt_out`.
- A zero pointer selects the lowest mask bit.
- A single-slot mask returns the pointer itself.
- The hold and load behaviour follows the strobe, and reset clears the block.

The position of the selected bit for a general pointer only shows up in the bench scenarios. So do the wrap-around, the lowest-bit rule for a multi-bit pointer, and the rotation order under write-back. The bench runs all pointer and mask pairs at 4 slots against a loop model, and random patterns at 16 slots.

// File: rtl/rrpick_pkg.sv
// Shared constants and helpers for the circular slot picker.
// Assumes: slot counts are positive.
package rrpick_pkg;
    localparam int RRP_DEF_SLOTS = 8;

    // Map an unrolled chain stage onto its slot index.
    function automatic int rrp_wrap(input int idx, input int slots);
        return idx % slots;
    endfunction
endpackage

// File: rtl/rrpick_regs.sv
// Holding registers for pointer and mask, loaded on a strobe.
// Assumes: synchronous active-low reset clears both to zero.
module rrpick_regs #(
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SLOTS-1:0] cur_d,
    input  logic [SLOTS-1:0] mask_d,
    output logic [SLOTS-1:0] cur_q,
    output logic [SLOTS-1:0] mask_q
);
    // Capture pointer and mask when strobed; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            cur_q  <= cur_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/rrpick_anchor.sv
// Turns the held pointer into a one-hot seed vector for the search chain.
// seed[i] high means the search begins at slot i (inclusive).
// Keeps only the lowest set pointer bit; an all-zero pointer is treated
// as sitting just below slot 0 through a NOR detect on the slot-0 seed.
// Assumes: SLOTS >= 1.
module rrpick_anchor #(
    parameter int SLOTS = 8
) (
    input  logic [SLOTS-1:0] cur,
    output logic [SLOTS-1:0] seed
);
    logic [SLOTS-1:0] below;   // some pointer bit set under index i
    logic [SLOTS-1:0] ptr;     // lowest set pointer bit only
    logic             empty;   // pointer has no bit set

    assign below[0] = 1'b0;
    for (genvar i = 1; i < SLOTS; i++) begin : g_below
        assign below[i] = below[i-1] | cur[i-1];
    end

    assign ptr   = cur & ~below;
    assign empty = ~|cur;

    // Slot 0 starts after the top slot, or immediately when the pointer is empty.
    assign seed[0] = ptr[SLOTS-1] | empty;
    for (genvar i = 1; i < SLOTS; i++) begin : g_seed
        assign seed[i] = ptr[i-1];
    end
endmodule

// File: rtl/rrpick_ring.sv
// Linear search chain: a token enters at the seeded slot, passes through
// slots whose mask bit is clear, and stops at the first set mask bit.
// The ring is unrolled into two passes so no combinational loop forms.
// Assumes: seed has at most one bit set.
module rrpick_ring
    import rrpick_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic [SLOTS-1:0] seed,
    input  logic [SLOTS-1:0] mask,
    output logic [SLOTS-1:0] grant
);
    localparam int STAGES = 2 * SLOTS;

    logic [STAGES-1:0] tok;   // token present entering stage
    logic [STAGES-1:0] hit;   // token captured at stage

    assign tok[0] = seed[0];

    for (genvar j = 0; j < STAGES; j++) begin : g_stage
        localparam int POS = rrp_wrap(j, SLOTS);
        assign hit[j] = tok[j] & mask[POS];
        if (j + 1 < STAGES) begin : g_link
            if (j + 1 < SLOTS) begin : g_seeded
                assign tok[j+1] = (tok[j] & ~mask[POS]) | seed[j+1];
            end else begin : g_pass
                assign tok[j+1] = tok[j] & ~mask[POS];
            end
        end
    end

    // Fold both passes back onto the slot positions.
    for (genvar i = 0; i < SLOTS; i++) begin : g_fold
        assign grant[i] = hit[i] | hit[i+SLOTS];
    end
endmodule

// File: rtl/rr_slot_picker.sv
// Circular next-set-bit selector with held pointer and mask registers.
// nxt_out follows the held registers combinationally.
// Assumes: software writes nxt_out back as the next pointer.
module rr_slot_picker #(
    parameter int SLOTS = rrpick_pkg::RRP_DEF_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SLOTS-1:0] cur_in,
    input  logic [SLOTS-1:0] mask_in,
    output logic [SLOTS-1:0] nxt_out,
    output logic             nxt_valid
);
    logic [SLOTS-1:0] cur_q;
    logic [SLOTS-1:0] mask_q;
    logic [SLOTS-1:0] seed;

    rrpick_regs #(.SLOTS(SLOTS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .cur_d  (cur_in),
        .mask_d (mask_in),
        .cur_q  (cur_q),
        .mask_q (mask_q)
    );

    rrpick_anchor #(.SLOTS(SLOTS)) u_anchor (
        .cur  (cur_q),
        .seed (seed)
    );

    rrpick_ring #(.SLOTS(SLOTS)) u_ring (
        .seed  (seed),
        .mask  (mask_q),
        .grant (nxt_out)
    );

    assign nxt_valid = |mask_q;
endmodule

// File: rtl/rr_slot_picker_chk.sv
// Property checker for rr_slot_picker, attached by bind.
// Assumes: synchronous active-low reset.
module rr_slot_picker_chk #(
    parameter int SLOTS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SLOTS-1:0] cur_in,
    input logic [SLOTS-1:0] held_cur,
    input logic [SLOTS-1:0] held_mask,
    input logic [SLOTS-1:0] nxt_out,
    input logic             nxt_valid
);
    localparam logic [SLOTS-1:0] ONE = SLOTS'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (nxt_out == '0 && !nxt_valid && held_cur == '0)); // R1

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(nxt_out)); // R2

    AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> held_cur == $past(cur_in)); // R2

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(held_cur) && held_mask == held_cur) |-> nxt_out == held_cur); // R4

    AST_EMPTY_PTR_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (held_cur == '0 && held_mask != '0) |-> nxt_out == (held_mask & (~held_mask + ONE))); // R5

    AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_valid |-> nxt_out != '0); // R7

    AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !nxt_valid |-> nxt_out == '0); // R7

    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nxt_out)); // R8

    AST_INSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_out & ~held_mask) == '0); // R8
endmodule

bind rr_slot_picker rr_slot_picker_chk #(.SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .cur_in    (cur_in),
    .held_cur  (cur_q),
    .held_mask (mask_q),
    .nxt_out   (nxt_out),
    .nxt_valid (nxt_valid)
);

// File: tb/rr_slot_picker_tb.sv
// Self-checking bench: vector table, exhaustive 4-slot sweep, directed
// reset/hold/rotation tests, and random 16-slot patterns.
module rr_slot_picker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr4 = 1'b0;
    logic [3:0] cur4 = '0;
    logic [3:0] msk4 = '0;
    logic [3:0] nxt4;
    logic       val4;
    logic        wr16 = 1'b0;
    logic [15:0] cur16 = '0;
    logic [15:0] msk16 = '0;
    logic [15:0] nxt16;
    logic        val16;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    rr_slot_picker #(.SLOTS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr4), .cur_in(cur4),
        .mask_in(msk4), .nxt_out(nxt4), .nxt_valid(val4)
    );

    rr_slot_picker #(.SLOTS(16)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .wr_en(wr16), .cur_in(cur16),
        .mask_in(msk16), .nxt_out(nxt16), .nxt_valid(val16)
    );

    // {pointer, mask, expected next}
    localparam logic [11:0] VEC [12] = '{
        12'b0001_1111_0010,  // R3
        12'b0010_1111_0100,  // R3
        12'b1000_1111_0001,  // R3 wrap
        12'b0100_0101_0001,  // R3 wrap
        12'b0010_0010_0010,  // R4
        12'b0000_1100_0100,  // R5
        12'b0000_0001_0001,  // R5
        12'b0110_1001_1000,  // R6
        12'b1010_0101_0100,  // R6
        12'b0100_0000_0000,  // R7
        12'b0001_0001_0001,  // R4
        12'b0001_1000_1000   // R3
    };
    localparam int VREQ [12] = '{3, 3, 3, 3, 4, 5, 5, 6, 6, 7, 4, 3};

    function automatic logic [15:0] ref_next(input logic [15:0] cur,
                                             input logic [15:0] msk,
                                             input int k);
        int p;
        p = -1;
        for (int i = k - 1; i >= 0; i--) if (cur[i]) p = i;
        for (int d = 1; d <= k; d++) begin
            int idx;
            idx = (p + d) % k;
            if (msk[idx]) return 16'(1) << idx;
        end
        return '0;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply4(input logic [3:0] c, input logic [3:0] m);
        @(negedge clk);
        cur4 = c; msk4 = m; wr4 = 1'b1;
        @(negedge clk);
        wr4 = 1'b0;
    endtask

    task automatic apply16(input logic [15:0] c, input logic [15:0] m);
        @(negedge clk);
        cur16 = c; msk16 = m; wr16 = 1'b1;
        @(negedge clk);
        wr16 = 1'b0;
    endtask

    initial begin
        #1ms;
        n_err++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [3:0] exp4;
        logic [15:0] e16;
        repeat (3) @(negedge clk);
        chk(nxt4 == 4'd0 && !val4, "R1 reset state", {12'd0, nxt4}, 16'd0);
        rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < 12; v++) begin
            apply4(VEC[v][11:8], VEC[v][7:4]);
            chk(nxt4 == VEC[v][3:0], $sformatf("R%0d table row %0d", VREQ[v], v),
                {12'd0, nxt4}, {12'd0, VEC[v][3:0]});
        end

        // Exhaustive sweep, 4 slots (R3 R5 R6 R7)
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < 16; m++) begin
                apply4(4'(c), 4'(m));
                exp4 = 4'(ref_next(16'(c), 16'(m), 4));
                chk(nxt4 == exp4, "R3 sweep next", {12'd0, nxt4}, {12'd0, exp4});
                chk(val4 == (m != 0), "R7 sweep valid", {15'd0, val4}, {15'd0, m != 0});
            end
        end

        // Hold without strobe (R2)
        apply4(4'b0001, 4'b0110);
        @(negedge clk);
        cur4 = 4'b1000; msk4 = 4'b1111;
        repeat (3) @(negedge clk);
        chk(nxt4 == 4'b0010, "R2 hold", {12'd0, nxt4}, 16'h0002);

        // Mid-run reset (R1)
        apply4(4'b0010, 4'b1111);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(nxt4 == 4'd0 && !val4, "R1 mid-run reset", {12'd0, nxt4}, 16'd0);

        // Rotation by write-back (R9)
        apply4(4'b0000, 4'b1101);
        chk(nxt4 == 4'b0001, "R9 rotate start", {12'd0, nxt4}, 16'h0001);
        begin
            logic [3:0] seq [4];
            seq = '{4'b0100, 4'b1000, 4'b0001, 4'b0100};
            for (int s = 0; s < 4; s++) begin
                apply4(nxt4, 4'b1101);
                chk(nxt4 == seq[s], "R9 rotate step", {12'd0, nxt4}, {12'd0, seq[s]});
            end
        end

        // Random 16-slot patterns (R3 R5 R6 R8)
        for (int r = 0; r < 300; r++) begin
            logic [15:0] c;
            logic [15:0] m;
            case (r % 3)
                0: c = 16'(1) << ($urandom % 16);
                1: c = '0;
                default: c = 16'($urandom);
            endcase
            m = (r % 2 == 0) ? 16'($urandom) : 16'($urandom & $urandom & $urandom);
            apply16(c, m);
            e16 = ref_next(c, m, 16);
            chk(nxt16 == e16, "R3 wide random", nxt16, e16);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule